// File: doc/BRIEF.md
# Serial Codec Control-Word Decoder

This block sits on the codec side of a serial link. It receives one 16-bit word per frame. The serial shifting has already been done, so each word arrives as a parallel word with a one-cycle valid strobe. The block keeps a small bank of 8-bit configuration registers. Bit 0 of register A is the mode flag. While that flag is clear, the block is in program mode: each incoming word is read as a control word that can write or read a configuration register. Once the flag is set, the block is in data mode: every incoming word is forwarded as a 16-bit DAC sample.

For each received frame, the block also builds the 16-bit word that goes back to the host, with a flag that says whether the word carries meaning.
- In data mode the return word is the ADC sample presented with the frame.
- In program mode the return word is normally marked invalid.
- Two program-mode responses are marked valid: the answer to a register read, and the echo of a write word when echo is enabled.

Top module: `ctlword_rx`

## Requirements
- R1: After reset every configuration register reads 0, `data_mode` is 0, and `tx_stb`, `tx_ok` and `dac_stb` are 0.
- R2: In program mode, a frame is a write when `rx_word[15]`=1, `rx_word[14]`=0 and `rx_word[13:11]` equals `DEV_ADDR` (default 0). A write stores `rx_word[7:0]` into register `rx_word[10:8]` (A=0, B=1, C=2). The new value is visible on `cfg_regs[idx*8 +: 8]` on the clock edge that accepts the frame.
- R3: In program mode, a frame leaves every register unchanged if any of these holds: `rx_word[15]` is 0, `rx_word[13:11]` differs from `DEV_ADDR`, or the register index is `NUM_REGS` or higher.
- R4: Setting bit 0 of register A switches the block to data mode. The return word for that same frame is still formed under program-mode rules. Data mode is left only through reset.
- R5: In data mode, every frame copies `rx_word` to `dac_word` and pulses `dac_stb` for one cycle. The registers are never written, even when `rx_word[15]` is 1. In program mode `dac_stb` stays 0.
- R6: Every frame produces one `tx_stb` pulse, registered on the accepting edge. In data mode `tx_word` equals the `adc_sample` presented with the frame, and `tx_ok` is 1.
- R7: In program mode, a frame that is neither an addressed read nor an echoed write returns `tx_word`=0 with `tx_ok`=0.
- R8: In program mode, an addressed read has `rx_word[15]`=1, `rx_word[14]`=1 and a matching address. It returns `tx_word` = {`rx_word[15:8]`, the register's value} with `tx_ok`=1, and changes no register. An out-of-range index reads as 0.
- R9: When bit 1 of register A is 1 at the time an addressed write arrives, that write is returned unchanged on `tx_word` with `tx_ok`=1. The echo decision uses the value of register A held before the frame.
- R10: A cycle with `rx_valid`=0 produces no strobe and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received word is present |
| rx_word | input | 16 | Received word |
| adc_sample | input | 16 | ADC sample to return for this frame |
| cfg_regs | output | NUM_REGS*8 | Configuration registers, register i at bits i*8+7..i*8 |
| data_mode | output | 1 | 1 in data mode, 0 in program mode |
| dac_word | output | 16 | Last DAC sample forwarded |
| dac_stb | output | 1 | One-cycle strobe for a new DAC sample |
| tx_stb | output | 1 | One-cycle strobe for a new return word |
| tx_word | output | 16 | Return word for the last frame |
| tx_ok | output | 1 | Return word carries a valid ADC sample or a valid response |

## Verification
The assertions assume that `rx_valid` is a clean single-cycle pulse per frame. They also assume that `rx_word` and `adc_sample` are stable at the edge where `rx_valid` is high. The stimulus raises `rx_valid` for exactly one cycle per word, with both data inputs set half a cycle before the edge, and always lowers it before the next frame. The properties also treat `data_mode` as set only by an accepted write to register A. The directed sequence therefore enters data mode only through such a write, and leaves it only through reset.

// File: rtl/ctlword_pkg.sv
package ctlword_pkg;

    localparam int WORD_W  = 16;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = 3;
    localparam int DEV_W   = 3;
    localparam int MODE_BIT = 0;
    localparam int ECHO_BIT = 1;

    typedef struct packed {
        logic              is_ctl;
        logic              is_read;
        logic [DEV_W-1:0]  dev;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } ctl_word_t;

    typedef enum logic [1:0] {
        RESP_NONE = 2'd0,
        RESP_ADC  = 2'd1,
        RESP_READ = 2'd2,
        RESP_ECHO = 2'd3
    } resp_kind_t;

    function automatic ctl_word_t split_word(input logic [WORD_W-1:0] w);
        return ctl_word_t'(w);
    endfunction

    function automatic resp_kind_t pick_resp(input logic in_data,
                                             input logic rd_hit,
                                             input logic wr_hit,
                                             input logic echo_en);
        if (in_data)              return RESP_ADC;
        else if (rd_hit)          return RESP_READ;
        else if (wr_hit && echo_en) return RESP_ECHO;
        else                      return RESP_NONE;
    endfunction

endpackage

// File: rtl/ctlword_decode.sv
module ctlword_decode
    import ctlword_pkg::*;
#(
    parameter logic [2:0] DEV_ADDR = 3'd0
) (
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    input  logic              in_data,
    output logic              wr_hit,
    output logic              rd_hit,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] data
);
    ctl_word_t cw;
    logic      addressed;

    always_comb begin
        cw        = split_word(word);
        addressed = valid && !in_data && cw.is_ctl && (cw.dev == DEV_ADDR);
        wr_hit    = addressed && !cw.is_read;
        rd_hit    = addressed &&  cw.is_read;
        idx       = cw.idx;
        data      = cw.data;
    end
endmodule

// File: rtl/ctlword_regfile.sv
module ctlword_regfile
    import ctlword_pkg::*;
#(
    parameter int NUM_REGS = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat,
    output logic                       mode_flag,
    output logic                       echo_flag
);
    logic [DATA_W-1:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= '0;
            else if (wr_en && (wr_idx == SLOT))
                bank[g] <= wr_data;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = bank[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_data = bank[i];
        end
    end

    assign mode_flag = bank[0][MODE_BIT];
    assign echo_flag = bank[0][ECHO_BIT];
endmodule

// File: rtl/ctlword_resp.sv
module ctlword_resp
    import ctlword_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  resp_kind_t        kind,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [WORD_W-1:0] adc_sample,
    input  logic [DATA_W-1:0] rd_data,
    output logic              tx_stb,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_ok
);
    logic [WORD_W-1:0] nxt_word;
    logic              nxt_ok;

    always_comb begin
        unique case (kind)
            RESP_ADC:  begin nxt_word = adc_sample;                         nxt_ok = 1'b1; end
            RESP_READ: begin nxt_word = {rx_word[WORD_W-1:DATA_W], rd_data}; nxt_ok = 1'b1; end
            RESP_ECHO: begin nxt_word = rx_word;                            nxt_ok = 1'b1; end
            default:   begin nxt_word = '0;                                 nxt_ok = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_stb  <= 1'b0;
            tx_word <= '0;
            tx_ok   <= 1'b0;
        end else begin
            tx_stb <= fire;
            if (fire) begin
                tx_word <= nxt_word;
                tx_ok   <= nxt_ok;
            end
        end
    end
endmodule

// File: rtl/ctlword_rx.sv
module ctlword_rx
    import ctlword_pkg::*;
#(
    parameter int         NUM_REGS = 3,
    parameter logic [2:0] DEV_ADDR = 3'd0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_valid,
    input  logic [15:0]                rx_word,
    input  logic [15:0]                adc_sample,
    output logic [NUM_REGS*8-1:0]      cfg_regs,
    output logic                       data_mode,
    output logic [15:0]                dac_word,
    output logic                       dac_stb,
    output logic                       tx_stb,
    output logic [15:0]                tx_word,
    output logic                       tx_ok
);
    logic              wr_hit, rd_hit, echo_en;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wdata, rd_data;
    resp_kind_t        kind;

    ctlword_decode #(.DEV_ADDR(DEV_ADDR)) u_dec (
        .valid   (rx_valid),
        .word    (rx_word),
        .in_data (data_mode),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit),
        .idx     (idx),
        .data    (wdata)
    );

    ctlword_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_hit),
        .wr_idx    (idx),
        .wr_data   (wdata),
        .rd_idx    (idx),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs),
        .mode_flag (data_mode),
        .echo_flag (echo_en)
    );

    assign kind = pick_resp(data_mode, rd_hit, wr_hit, echo_en);

    ctlword_resp u_resp (
        .clk        (clk),
        .rst        (rst),
        .fire       (rx_valid),
        .kind       (kind),
        .rx_word    (rx_word),
        .adc_sample (adc_sample),
        .rd_data    (rd_data),
        .tx_stb     (tx_stb),
        .tx_word    (tx_word),
        .tx_ok      (tx_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_word <= '0;
            dac_stb  <= 1'b0;
        end else begin
            dac_stb <= rx_valid && data_mode;
            if (rx_valid && data_mode)
                dac_word <= rx_word;
        end
    end
endmodule

// File: rtl/ctlword_rx_chk.sv
module ctlword_rx_chk #(
    parameter int NUM_REGS = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  rx_valid,
    input logic [15:0]           rx_word,
    input logic [15:0]           adc_sample,
    input logic [NUM_REGS*8-1:0] cfg_regs,
    input logic                  data_mode,
    input logic [15:0]           dac_word,
    input logic                  dac_stb,
    input logic                  tx_stb,
    input logic [15:0]           tx_word,
    input logic                  tx_ok
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cfg_regs == '0) && !data_mode && !tx_stb && !dac_stb && !tx_ok); // R1

    AST_FRAME_STROBE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> tx_stb); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !tx_stb && !dac_stb && $stable(cfg_regs)); // R10

    AST_DATA_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && data_mode) |=> dac_stb && (dac_word == $past(rx_word))); // R5

    AST_DATA_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        data_mode |=> $stable(cfg_regs)); // R5

    AST_PROG_NO_DAC: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !data_mode) |=> !dac_stb); // R5

    AST_ADC_RETURN: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && data_mode) |=> tx_ok && (tx_word == $past(adc_sample))); // R6

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        data_mode |=> data_mode); // R4

    AST_NONCTRL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !data_mode && !rx_word[15]) |=> $stable(cfg_regs) && !tx_ok); // R3
endmodule

bind ctlword_rx ctlword_rx_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_word    (rx_word),
    .adc_sample (adc_sample),
    .cfg_regs   (cfg_regs),
    .data_mode  (data_mode),
    .dac_word   (dac_word),
    .dac_stb    (dac_stb),
    .tx_stb     (tx_stb),
    .tx_word    (tx_word),
    .tx_ok      (tx_ok)
);

// File: tb/ctlword_rx_test.sv
module ctlword_rx_test;
    localparam int NREG = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_valid = 1'b0;
    logic [15:0]       rx_word = '0;
    logic [15:0]       adc_sample = '0;
    logic [NREG*8-1:0] cfg_regs;
    logic              data_mode, dac_stb, tx_stb, tx_ok;
    logic [15:0]       dac_word, tx_word;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    ctlword_rx #(.NUM_REGS(NREG), .DEV_ADDR(3'd0)) uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word),
        .adc_sample(adc_sample), .cfg_regs(cfg_regs), .data_mode(data_mode),
        .dac_word(dac_word), .dac_stb(dac_stb), .tx_stb(tx_stb),
        .tx_word(tx_word), .tx_ok(tx_ok)
    );

    task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!good) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(input int i);
        return cfg_regs[i*8 +: 8];
    endfunction

    task automatic send(input logic [15:0] w, input logic [15:0] adc);
        @(negedge clk);
        rx_valid = 1'b1; rx_word = w; adc_sample = adc;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        chk(cfg_regs == '0, "R1 regs", 32'(cfg_regs), 0);
        chk(!data_mode && !tx_stb && !dac_stb && !tx_ok, "R1 flags",
            {data_mode, tx_stb, dac_stb, tx_ok}, 0);
    endtask

    task automatic t_first_frame();
        send(16'h0000, 16'h1234);
        chk(tx_stb && !tx_ok && tx_word == 16'h0, "R7 first frame invalid",
            {tx_stb, tx_ok, tx_word}, {2'b10, 16'h0});
    endtask

    task automatic t_writes();
        send(16'h8103, 16'h0);
        chk(reg_at(1) == 8'h03, "R2 write B", reg_at(1), 8'h03);
        chk(tx_stb && !tx_ok && tx_word == 0, "R7 write no echo", {tx_ok, tx_word}, 0);
        send(16'h8201, 16'h0);
        chk(reg_at(2) == 8'h01, "R2 write C", reg_at(2), 8'h01);
        chk(!data_mode, "R2 still program", data_mode, 0);
    endtask

    task automatic t_ignored();
        send(16'h8955, 16'h0);
        chk(reg_at(1) == 8'h03, "R3 wrong device", reg_at(1), 8'h03);
        send(16'h0155, 16'h0);
        chk(reg_at(1) == 8'h03, "R3 bit15 clear", reg_at(1), 8'h03);
        chk(!tx_ok, "R7 non-control invalid", tx_ok, 0);
        send(16'h8377, 16'h0);
        chk(cfg_regs == 24'h010300, "R3 index out of range", 32'(cfg_regs), 32'h010300);
    endtask

    task automatic t_reads();
        send(16'hC1AA, 16'h0);
        chk(tx_ok && tx_word == 16'hC103, "R8 read B", tx_word, 16'hC103);
        chk(reg_at(1) == 8'h03, "R8 read no change", reg_at(1), 8'h03);
        send(16'hC200, 16'h0);
        chk(tx_ok && tx_word == 16'hC201, "R8 read C", tx_word, 16'hC201);
        send(16'hC355, 16'h0);
        chk(tx_ok && tx_word == 16'hC300, "R8 read out of range", tx_word, 16'hC300);
        send(16'hC900, 16'h0);
        chk(!tx_ok && tx_word == 0, "R7 read wrong device", tx_word, 0);
    endtask

    task automatic t_idle();
        repeat (3) @(negedge clk);
        chk(!tx_stb && !dac_stb && cfg_regs == 24'h010300, "R10 idle",
            {tx_stb, dac_stb, 8'h0, cfg_regs}, 32'h010300);
    endtask

    task automatic t_echo();
        send(16'h8002, 16'h0);
        chk(!tx_ok && reg_at(0) == 8'h02, "R9 echo uses old A", {tx_ok, reg_at(0)}, 8'h02);
        send(16'h8144, 16'h0);
        chk(tx_ok && tx_word == 16'h8144, "R9 echo write", tx_word, 16'h8144);
        chk(reg_at(1) == 8'h44, "R9 echoed write applied", reg_at(1), 8'h44);
    endtask

    task automatic t_enter_data();
        send(16'h8003, 16'h5A5A);
        chk(data_mode, "R4 data mode set", data_mode, 1);
        chk(tx_ok && tx_word == 16'h8003 && !dac_stb, "R4 frame under program rules",
            {dac_stb, tx_word}, 16'h8003);
    endtask

    task automatic t_data();
        send(16'h7FFF, 16'h8000);
        chk(dac_stb && dac_word == 16'h7FFF, "R5 dac forward", dac_word, 16'h7FFF);
        chk(tx_ok && tx_word == 16'h8000, "R6 adc return", tx_word, 16'h8000);
        @(negedge clk);
        chk(!dac_stb && !tx_stb, "R5 strobe single cycle", {dac_stb, tx_stb}, 0);
        send(16'h8155, 16'h1357);
        chk(reg_at(1) == 8'h44 && dac_word == 16'h8155, "R5 control-like word is data",
            {reg_at(1), dac_word}, {8'h44, 16'h8155});
        chk(tx_word == 16'h1357 && tx_ok, "R6 second adc", tx_word, 16'h1357);
        chk(data_mode, "R4 mode sticky", data_mode, 1);
    endtask

    initial begin
        #400000;
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        do_reset();
        t_first_frame();
        t_writes();
        t_ignored();
        t_reads();
        t_idle();
        t_echo();
        t_enter_data();
        t_data();
        do_reset();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule